// File: doc/BRIEF.md
# Residue to Binary Converter (Chinese Remainder Reconstruction)

This block takes a number held as a tuple of residues, one per modulus of a pairwise coprime set, and turns it back into an ordinary binary integer in the range [0, M). M is the product of all the moduli. The reconstruction follows the Chinese remainder theorem. Each residue digit selects one entry from a small constant table. That entry is the digit's weighted share of the result, already reduced modulo M. The selected shares are then summed by a pipelined binary tree of modulo-M adders. Each adder subtracts M only when the raw sum reaches M, so no multiplier or divider appears in the datapath.

The moduli are parameters. All table contents, the output width and the tree shape are worked out when the design is elaborated. A tuple presented with `in_valid` high gives its result on `out_valid`/`out_value` a fixed number of cycles later. A new tuple can be accepted on every clock. The block is meant to sit at the output of a residue-arithmetic datapath, where the results have to be handed back in plain binary.

Top module: `crt_residue_to_binary`

## Requirements
- R1: When `out_valid` is high, `out_value` is the unique X in [0, M) with X mod m_i equal to residue digit i, for every digit i. Digit i sits at bits [i*RW +: RW] of `in_res` and must be less than its modulus.
- R2: With the default parameters, the moduli are 2, 3 and 5 for digits 0, 1 and 2, with RW = 3. This gives M = 30 and a 5-bit `out_value`.
- R3: With the default parameters, the three digit tables hold these shares. Digit 0 (mod 2): 0→0, 1→15. Digit 1 (mod 3): 0→0, 1→10, 2→20. Digit 2 (mod 5): 0→0, 1→6, 2→12, 3→18, 4→24. A tuple with a single nonzero digit therefore returns that digit's share.
- R4: A tuple sampled with `in_valid` high appears with `out_valid` high exactly 1 + ceil(log2(NDIG)) cycles later. That is 3 cycles for the default set. Tuples may arrive on every consecutive cycle.
- R5: A cycle in which `in_valid` is low gives a cycle with `out_valid` low at the same latency. Gaps in the input stream are kept in place in the output stream.
- R6: The reset is synchronous and active-low (`rst_n`). It forces `out_valid` low on the next clock. After reset, `out_valid` stays low until a valid tuple has passed through the pipeline.
- R7: Whenever `out_valid` is high, `out_value` is strictly less than M.
- R8: When a partial sum reaches or passes M, the adder wraps it by subtracting M. With the default set, tuple (1,2,4) gives 29 and tuple (1,2,0) gives 5, because the first level computes 15+20 = 35 and wraps it to 5.
- R9: The all-zero tuple gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_res` in this cycle |
| in_res | input | NDIG*RW | Residue tuple, digit i at bits [i*RW +: RW] |
| out_valid | output | 1 | Qualifies `out_value` |
| out_value | output | $clog2(M) | Reconstructed binary value in [0, M) |

## Verification
The bench builds two instances. The first uses the default set 2, 3 and 5 (M = 30, three digits, a two-level tree). This one exercises the exact table shares, the wrap cases and the gap and reset behaviour. The second uses the five moduli 3, 4, 5, 7 and 11 (M = 4620, RW = 4). It adds a three-level tree in which an odd node is carried through a level unchanged, and a 13-bit adder path. Both instances are swept exhaustively with back-to-back tuples produced by a behavioural forward conversion (x mod m_i), and every output is matched exactly against x.

// File: rtl/crt_pkg.sv
// crt_pkg: elaboration-time helpers for the residue-to-binary converter.
// Moduli are passed as a packed vector of 8-bit fields, digit i at [i*8 +: 8].
// Assumes the moduli are pairwise coprime and at least 2.
package crt_pkg;

    localparam int MODW   = 8;
    localparam int MAXDIG = 32;

    // Product of the first n moduli (the dynamic range M).
    function automatic longint range_of(input logic [MAXDIG*MODW-1:0] mods, input int n);
        longint p;
        p = 1;
        for (int i = 0; i < n; i++) begin
            p = p * longint'(mods[i*MODW +: MODW]);
        end
        return p;
    endfunction

    // Modulus of digit i.
    function automatic longint modulus_of(input logic [MAXDIG*MODW-1:0] mods, input int i);
        return longint'(mods[i*MODW +: MODW]);
    endfunction

    // Weighted share of residue r on digit i: (r * Mi * inv(Mi mod mi)) mod M.
    function automatic longint weight_entry(input logic [MAXDIG*MODW-1:0] mods,
                                            input int n, input int i, input int r);
        longint m;
        longint mi;
        longint big;
        longint inv;
        m   = range_of(mods, n);
        mi  = modulus_of(mods, i);
        big = m / mi;
        inv = 0;
        for (longint k = 1; k < mi; k++) begin
            if (((big % mi) * k) % mi == 1) inv = k;
        end
        return (longint'(r) * big * inv) % m;
    endfunction

    // Number of adder levels for n leaves: ceil(log2(n)).
    function automatic int tree_levels(input int n);
        int l;
        l = 0;
        while ((1 << l) < n) l++;
        return l;
    endfunction

    // Number of nodes at tree level l for n leaves: ceil(n / 2^l).
    function automatic int node_count(input int n, input int l);
        return (n + (1 << l) - 1) >> l;
    endfunction

endpackage

// File: rtl/crt_digit_table.sv
// crt_digit_table: constant lookup of one digit's weighted CRT share.
// Entries are computed at elaboration from the modulus set.
// Assumes res < modulus of this digit; out-of-range codes return 0.
module crt_digit_table #(
    parameter int      NDIG   = 3,
    parameter int      RW     = 3,
    parameter int      VW     = 5,
    parameter int      DIGIT  = 0,
    parameter logic [crt_pkg::MAXDIG*crt_pkg::MODW-1:0] MODS = '0
) (
    input  logic [RW-1:0] res,
    output logic [VW-1:0] share
);

    localparam int MI = int'(crt_pkg::modulus_of(MODS, DIGIT));

    logic [VW-1:0] tbl [MI];

    // One constant entry per residue code.
    for (genvar r = 0; r < MI; r++) begin : g_ent
        localparam longint ENT = crt_pkg::weight_entry(MODS, NDIG, DIGIT, r);
        assign tbl[r] = VW'(ENT);
    end

    // Select the entry matching the residue.
    always_comb begin
        share = '0;
        for (int r = 0; r < MI; r++) begin
            if (res == RW'(r)) share = tbl[r];
        end
    end

endmodule

// File: rtl/crt_mod_add.sv
// crt_mod_add: combinational modulo-M adder.
// Forms a+b, then a+b-M; the borrow out of the subtraction picks the result.
// Assumes both operands are below M, so one correction is enough.
module crt_mod_add #(
    parameter int     VW     = 5,
    parameter longint MRANGE = 30
) (
    input  logic [VW-1:0] a,
    input  logic [VW-1:0] b,
    output logic [VW-1:0] y
);

    logic [VW:0]   raw;
    logic [VW+1:0] corr;

    // Raw sum with one extra carry bit.
    assign raw  = {1'b0, a} + {1'b0, b};
    // Subtract M; the top bit is the borrow (raw below M).
    assign corr = {1'b0, raw} - (VW+2)'(MRANGE);
    // Keep the raw sum on borrow, otherwise the corrected one.
    assign y    = corr[VW+1] ? raw[VW-1:0] : corr[VW-1:0];

endmodule

// File: rtl/crt_add_tree.sv
// crt_add_tree: pipelined binary tree of modulo-M adders.
// Level 0 registers the table outputs. Each later level pairs nodes and
// registers the sums; an odd last node is carried through a register.
// Latency from leaves to root is 1 + ceil(log2(NDIG)) cycles.
module crt_add_tree #(
    parameter int     NDIG   = 3,
    parameter int     VW     = 5,
    parameter longint MRANGE = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NDIG*VW-1:0] leaves,
    output logic [VW-1:0]     root
);

    localparam int LEVELS = crt_pkg::tree_levels(NDIG);

    for (genvar l = 0; l <= LEVELS; l++) begin : lvl
        localparam int CNT = crt_pkg::node_count(NDIG, l);
        logic [VW-1:0] nxt [CNT];
        logic [VW-1:0] val [CNT];

        if (l == 0) begin : g_leaf
            for (genvar j = 0; j < CNT; j++) begin : g_in
                assign nxt[j] = leaves[j*VW +: VW];
            end
        end else begin : g_join
            localparam int PCNT = crt_pkg::node_count(NDIG, l - 1);
            for (genvar j = 0; j < CNT; j++) begin : g_node
                if (2*j + 1 < PCNT) begin : g_pair
                    crt_mod_add #(.VW(VW), .MRANGE(MRANGE)) u_add (
                        .a (lvl[l-1].val[2*j]),
                        .b (lvl[l-1].val[2*j+1]),
                        .y (nxt[j])
                    );
                end else begin : g_pass
                    assign nxt[j] = lvl[l-1].val[2*j];
                end
            end
        end

        // Level register: clear on reset, otherwise capture this level.
        always_ff @(posedge clk) begin
            for (int j = 0; j < CNT; j++) begin
                if (!rst_n) val[j] <= '0;
                else        val[j] <= nxt[j];
            end
        end
    end

    assign root = lvl[LEVELS].val[0];

endmodule

// File: rtl/crt_residue_to_binary.sv
// crt_residue_to_binary: CRT reconstruction of a binary value from residues.
// Each digit looks up its weighted share; the shares meet in a pipelined
// modulo-M adder tree. A valid bit travels alongside with matching latency.
// Assumes pairwise coprime moduli and residues below their moduli.
module crt_residue_to_binary #(
    parameter int NDIG = 3,
    parameter int RW   = 3,
    parameter logic [NDIG*8-1:0] MODULI = {8'd5, 8'd3, 8'd2},
    localparam longint MRANGE = crt_pkg::range_of(
        (crt_pkg::MAXDIG*crt_pkg::MODW)'(MODULI), NDIG),
    localparam int VW = $clog2(MRANGE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [NDIG*RW-1:0] in_res,
    output logic              out_valid,
    output logic [VW-1:0]     out_value
);

    localparam logic [crt_pkg::MAXDIG*crt_pkg::MODW-1:0] MODS =
        (crt_pkg::MAXDIG*crt_pkg::MODW)'(MODULI);
    localparam int LAT = 1 + crt_pkg::tree_levels(NDIG);

    logic [NDIG*VW-1:0] shares;
    logic [LAT-1:0]     vpipe;

    // One share table per residue digit.
    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        crt_digit_table #(
            .NDIG (NDIG), .RW (RW), .VW (VW), .DIGIT (i), .MODS (MODS)
        ) u_tbl (
            .res   (in_res[i*RW +: RW]),
            .share (shares[i*VW +: VW])
        );
    end

    crt_add_tree #(.NDIG(NDIG), .VW(VW), .MRANGE(MRANGE)) u_tree (
        .clk    (clk),
        .rst_n  (rst_n),
        .leaves (shares),
        .root   (out_value)
    );

    // Valid shift register matching the datapath latency.
    always_ff @(posedge clk) begin
        if (!rst_n) vpipe <= '0;
        else        vpipe <= (vpipe << 1) | LAT'(in_valid);
    end

    assign out_valid = vpipe[LAT-1];

endmodule

// File: rtl/crt_r2b_checker.sv
// crt_r2b_checker: protocol and range properties of crt_residue_to_binary.
// Keeps its own delay line of input qualifiers to check the output timing.
module crt_r2b_checker #(
    parameter int     NDIG   = 3,
    parameter int     RW     = 3,
    parameter longint MRANGE = 30,
    parameter int     VW     = 5,
    parameter int     LAT    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [NDIG*RW-1:0] in_res,
    input logic              out_valid,
    input logic [VW-1:0]     out_value
);

    logic [LAT-1:0] vhist;
    logic [LAT-1:0] zhist;

    // Delay line of accepted tuples and of accepted all-zero tuples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vhist <= '0;
            zhist <= '0;
        end else begin
            vhist <= (vhist << 1) | LAT'(in_valid);
            zhist <= (zhist << 1) | LAT'(in_valid && (in_res == '0));
        end
    end

    // R4 and R5: output qualifier follows the input qualifier by LAT cycles.
    a_r4_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vhist[LAT-1]);

    // R7: a qualified result lies below M.
    a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (longint'(out_value) < MRANGE));

    // R6: reset clears the output qualifier on the following edge.
    a_r6_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R9: the all-zero tuple reconstructs to zero.
    a_r9_zero_tuple: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && zhist[LAT-1]) |-> (out_value == '0));

endmodule

bind crt_residue_to_binary crt_r2b_checker #(
    .NDIG (NDIG), .RW (RW), .MRANGE (MRANGE), .VW (VW), .LAT (LAT)
) u_chk (.*);

// File: tb/sim_crt_residue_to_binary.sv
`timescale 1ns/1ps
module sim_crt_residue_to_binary;

    localparam int LAT_A = 3;     // 1 + ceil(log2(3))
    localparam int M_A   = 30;
    localparam int LAT_B = 4;     // 1 + ceil(log2(5))
    localparam int M_B   = 4620;

    // Directed vectors for the default set: r0 (mod 2), r1 (mod 3), r2 (mod 5), expected.
    localparam int NVEC = 10;
    localparam int VEC [NVEC][4] = '{
        '{0, 0, 0, 0},  '{1, 0, 0, 15}, '{0, 1, 0, 10}, '{0, 2, 0, 20},
        '{0, 0, 1, 6},  '{0, 0, 3, 18}, '{0, 0, 4, 24}, '{1, 2, 4, 29},
        '{1, 2, 0, 5},  '{1, 1, 1, 1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_valid = 1'b0;
    logic [8:0]  a_res = '0;
    logic        a_ov;
    logic [4:0]  a_out;
    logic        b_valid = 1'b0;
    logic [19:0] b_res = '0;
    logic        b_ov;
    logic [12:0] b_out;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    crt_residue_to_binary u0 (
        .clk (clk), .rst_n (rst_n), .in_valid (a_valid), .in_res (a_res),
        .out_valid (a_ov), .out_value (a_out)
    );

    crt_residue_to_binary #(
        .NDIG (5), .RW (4), .MODULI ({8'd11, 8'd7, 8'd5, 8'd4, 8'd3})
    ) u1 (
        .clk (clk), .rst_n (rst_n), .in_valid (b_valid), .in_res (b_res),
        .out_valid (b_ov), .out_value (b_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural forward conversions.
    function automatic logic [8:0] fwd_a(input int x);
        return {3'(x % 5), 3'(x % 3), 3'(x % 2)};
    endfunction

    function automatic logic [19:0] fwd_b(input int x);
        return {4'(x % 11), 4'(x % 7), 4'(x % 5), 4'(x % 4), 4'(x % 3)};
    endfunction

    // Stream value t (mod M) in slot t when mask bit set; check every output slot.
    task automatic seq_a(input int len, input logic [63:0] mask, input string tag);
        for (int t = 0; t < len + LAT_A; t++) begin
            @(negedge clk);
            if (t >= LAT_A) begin
                check(a_ov == mask[t-LAT_A], tag, int'(a_ov), int'(mask[t-LAT_A]));
                if (mask[t-LAT_A])
                    check(a_out == 5'((t - LAT_A) % M_A), tag, int'(a_out), (t - LAT_A) % M_A);
            end else begin
                check(a_ov == 1'b0, tag, int'(a_ov), 0);
            end
            if (t < len) begin
                a_valid = mask[t];
                a_res   = fwd_a(t % M_A);
            end else begin
                a_valid = 1'b0;
            end
        end
    endtask

    // Exhaustive back-to-back sweep of the five-modulus instance.
    task automatic sweep_b();
        for (int t = 0; t < M_B + LAT_B; t++) begin
            @(negedge clk);
            if (t >= LAT_B) begin
                check(b_ov == 1'b1, "R4 u1 valid", int'(b_ov), 1);
                check(b_out == 13'(t - LAT_B), "R1 u1 value", int'(b_out), t - LAT_B);
            end
            if (t < M_B) begin
                b_valid = 1'b1;
                b_res   = fwd_b(t);
            end else begin
                b_valid = 1'b0;
            end
        end
        @(negedge clk);
        check(b_ov == 1'b0, "R5 u1 drain", int'(b_ov), 0);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        // R6: reset state.
        repeat (3) @(negedge clk);
        check(a_ov == 1'b0, "R6 reset u0", int'(a_ov), 0);
        check(b_ov == 1'b0, "R6 reset u1", int'(b_ov), 0);
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(a_ov == 1'b0, "R6 idle after reset", int'(a_ov), 0);
        end

        // R2 R3 R8 R9: directed vectors, one tuple at a time.
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            a_valid = 1'b1;
            a_res   = {3'(VEC[v][2]), 3'(VEC[v][1]), 3'(VEC[v][0])};
            @(negedge clk);
            a_valid = 1'b0;
            repeat (LAT_A - 2) @(negedge clk);
            check(a_ov == 1'b0, "R4 not early", int'(a_ov), 0);
            @(negedge clk);
            check(a_ov == 1'b1, "R4 on time", int'(a_ov), 1);
            check(a_out == 5'(VEC[v][3]), "R3 R8 R9 vector", int'(a_out), VEC[v][3]);
            @(negedge clk);
            check(a_ov == 1'b0, "R5 single pulse", int'(a_ov), 0);
        end

        // R1 R2: exhaustive back-to-back sweep of the default set.
        seq_a(M_A, '1, "R1 u0 sweep");
        // R5: gaps in the stream keep their place.
        seq_a(12, 64'b1011_0011_0101, "R5 gap pattern");
        // R1: second sweep crossing the wrap of t mod M.
        seq_a(40, '1, "R1 u0 wrap sweep");

        // R1 R4: exhaustive sweep of the five-modulus instance.
        sweep_b();

        // R6: reset in the middle of a stream discards in-flight tuples.
        @(negedge clk);
        a_valid = 1'b1;
        a_res   = fwd_a(7);
        b_valid = 1'b1;
        b_res   = fwd_b(123);
        @(negedge clk);
        a_res   = fwd_a(8);
        b_res   = fwd_b(124);
        @(negedge clk);
        a_valid = 1'b0;
        b_valid = 1'b0;
        rst_n   = 1'b0;
        @(negedge clk);
        check(a_ov == 1'b0, "R6 reset mid-stream u0", int'(a_ov), 0);
        check(b_ov == 1'b0, "R6 reset mid-stream u1", int'(b_ov), 0);
        rst_n = 1'b1;
        for (int k = 0; k < LAT_B + 1; k++) begin
            @(negedge clk);
            check(a_ov == 1'b0, "R6 flushed u0", int'(a_ov), 0);
            check(b_ov == 1'b0, "R6 flushed u1", int'(b_ov), 0);
        end

        // R7: largest value of each instance.
        @(negedge clk);
        a_valid = 1'b1;
        a_res   = fwd_a(M_A - 1);
        b_valid = 1'b1;
        b_res   = fwd_b(M_B - 1);
        @(negedge clk);
        a_valid = 1'b0;
        b_valid = 1'b0;
        repeat (LAT_A - 1) @(negedge clk);
        check(a_ov && a_out == 5'(M_A - 1), "R7 top u0", int'(a_out), M_A - 1);
        @(negedge clk);
        check(b_ov && b_out == 13'(M_B - 1), "R7 top u1", int'(b_out), M_B - 1);

        report();
        $finish;
    end

endmodule